// File: doc/BRIEF.md
# Bulk Erase Sequencer with Resumable Verify

This controller sits on the host side of a byte-wide flash device and carries out a complete erase of the array. It first writes 00H into every byte, using repeated program pulses. After each pulse it reads the byte back under program-verify and retries until the byte reads 00H. Once the whole array holds 00H, it fires timed whole-array erase pulses. After each erase pulse it runs an erase-verify scan that expects FFH at every byte.

A verify scan climbs through the array address by address. The scan stops at the first byte that is not yet FFH and stores that byte's address in a resume register. The scan after the next erase pulse starts at that stored address, so bytes that have already verified are not read again. When a scan reaches the top address with every byte at FFH, the controller writes 00H to put the device back in read-array mode and raises `done`. A parameter caps the number of erase pulses. A second parameter caps the program attempts per byte. Going over either cap ends the run with `error`.

The device is reached through a command stream and a read-response stream, both valid/ready. A command stays on `cmd_valid`/`cmd_write`/`cmd_addr`/`cmd_data` with all fields unchanged until the device raises `cmd_ready`. No more than one read is in flight at any time. `rsp_ready` is high only while the controller waits for that read's data, and no command is offered during that time. The device may hold back either stream for any number of cycles.

Top module: `bulk_erase_seq`

## Requirements
- R1: After reset, and whenever reset is asserted during a run, `busy`, `done`, `error` and `cmd_valid` are low.
- R2: Preconditioning handles each address in ascending order with a fixed command sequence:
  - write 40H;
  - write data 00H at the address;
  - wait at least PROG_CYCLES cycles;
  - write C0H at the address;
  - read the address.
  A read value of 00H moves to the next address. Any other value repeats the sequence for the same address.
- R3: If a byte still does not read 00H after MAX_PROG program attempts, the run ends with `error`, and no erase command (20H) is ever written.
- R4: Each erase pulse is started by two consecutive writes of 20H. The first pulse is issued only after every byte of the array reads 00H.
- R5: After the second 20H write, the controller issues no command for at least ERASE_CYCLES cycles. The number of erase pulses equals the number the slowest byte needs, as long as that number does not exceed MAX_ERASE.
- R6: Each verify step writes A0H at the address and then reads it. A value of FFH moves the scan to the next address.
- R7: The first verify after erase pulse 1 is at address 0. The first verify after every later pulse is at the address that failed in the previous scan. The stored resume address never decreases during a run.
- R8: When the top address (2^ADDR_W−1) verifies as FFH, the controller writes 00H and then holds `done` high.
- R9: If a scan fails after MAX_ERASE pulses, the run ends with `error`. If the slowest byte clears on pulse MAX_ERASE exactly, the run ends with `done`. `done` and `error` are never high together.
- R10: A command that is stalled keeps `cmd_valid` high and all of its fields unchanged until it is accepted. `rsp_ready` is never high while `cmd_valid` is high.
- R11: `done` or `error` stays high, with `busy` and `cmd_valid` low, until the next `start`. A `start` in that state begins a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; acted on when not busy |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed with the array erased |
| error | output | 1 | Last run stopped on a program or erase limit |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Device accepts the offered command |
| cmd_write | output | 1 | 1 = write cycle, 0 = read cycle |
| cmd_addr | output | ADDR_W | Byte address of the command |
| cmd_data | output | 8 | Write data or command code |
| rsp_valid | input | 1 | Read data is available |
| rsp_ready | output | 1 | Controller waits for read data |
| rsp_data | input | 8 | Byte returned by the read |

## Verification
The key collision is between reaching the pulse cap and a verify result on that same final pulse. Both decisions are made on the single response that ends the scan, so `done` and `error` compete in one cycle. The stimulus table includes an array whose slowest byte needs exactly MAX_ERASE pulses, which must end in `done`. It also includes an array whose slowest byte needs one pulse more, which must end in `error` after MAX_ERASE pulses. The outcome, the pulse count and the exclusivity of the two flags are checked in both cases. The same pairing is tested for program attempts: a byte needing exactly MAX_PROG attempts must pass, and one needing more must fail before any erase command appears.

// File: rtl/bes_pkg.sv
package bes_pkg;
  localparam logic [7:0] OP_PROG_SETUP   = 8'h40;
  localparam logic [7:0] OP_PROG_VERIFY  = 8'hC0;
  localparam logic [7:0] OP_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] OP_ERASE_VERIFY = 8'hA0;
  localparam logic [7:0] OP_READ_ARRAY   = 8'h00;
  localparam logic [7:0] BYTE_CHARGED    = 8'h00;
  localparam logic [7:0] BYTE_ERASED     = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_P_SETUP, S_P_DATA, S_P_WAIT, S_P_VCMD, S_P_READ, S_P_RESP,
    S_E_SET1, S_E_SET2, S_E_WAIT, S_V_CMD, S_V_READ, S_V_RESP,
    S_FINISH, S_DONE, S_FAIL
  } seq_state_e;
endpackage

// File: rtl/bes_pulse_timer.sv
module bes_pulse_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/bes_addr_track.sv
module bes_addr_track #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_cur,
  input  logic          clr_resume,
  input  logic          inc,
  input  logic          restore,
  input  logic          save,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] resume,
  output logic          at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= '0;
    else if (clr_cur) cur <= '0;
    else if (restore) cur <= resume;
    else if (inc)     cur <= cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          resume <= '0;
    else if (clr_resume) resume <= '0;
    else if (save)       resume <= cur;
  end

  assign at_last = (cur == {AW{1'b1}});
endmodule

// File: rtl/bes_attempt_ctr.sv
module bes_attempt_ctr #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (inc && !at_limit) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q >= LIM);
endmodule

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq
  import bes_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int MAX_PROG     = 25,
  parameter int MAX_ERASE    = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data
);
  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int TW = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] PROG_LOAD  = TW'(PROG_CYCLES - 1);
  localparam logic [TW-1:0] ERASE_LOAD = TW'(ERASE_CYCLES - 1);

  seq_state_e state_q, state_d;

  logic              cmd_fire, rsp_fire;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              a_clr_cur, a_clr_res, a_inc, a_restore, a_save, a_last;
  logic [ADDR_W-1:0] cur_addr, resume_q;
  logic              p_clr, p_inc, p_limit;
  logic              e_clr, e_inc, e_limit;

  assign cmd_fire = cmd_valid & cmd_ready;
  assign rsp_fire = rsp_valid & rsp_ready;

  bes_pulse_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  bes_addr_track #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr_cur(a_clr_cur), .clr_resume(a_clr_res),
    .inc(a_inc), .restore(a_restore), .save(a_save),
    .cur(cur_addr), .resume(resume_q), .at_last(a_last)
  );

  bes_attempt_ctr #(.LIMIT(MAX_PROG)) u_prog_ctr (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .inc(p_inc), .at_limit(p_limit)
  );

  bes_attempt_ctr #(.LIMIT(MAX_ERASE)) u_erase_ctr (
    .clk(clk), .rst_n(rst_n), .clr(e_clr), .inc(e_inc), .at_limit(e_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d   = state_q;
    cmd_valid = 1'b0;
    cmd_write = 1'b1;
    cmd_data  = OP_READ_ARRAY;
    rsp_ready = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = PROG_LOAD;
    a_clr_cur = 1'b0;
    a_clr_res = 1'b0;
    a_inc     = 1'b0;
    a_restore = 1'b0;
    a_save    = 1'b0;
    p_clr     = 1'b0;
    p_inc     = 1'b0;
    e_clr     = 1'b0;
    e_inc     = 1'b0;

    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          a_clr_cur = 1'b1;
          a_clr_res = 1'b1;
          p_clr     = 1'b1;
          e_clr     = 1'b1;
          state_d   = S_P_SETUP;
        end
      end
      S_P_SETUP: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_PROG_SETUP;
        if (cmd_fire) state_d = S_P_DATA;
      end
      S_P_DATA: begin
        cmd_valid = 1'b1;
        cmd_data  = BYTE_CHARGED;
        if (cmd_fire) begin
          p_inc    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = PROG_LOAD;
          state_d  = S_P_WAIT;
        end
      end
      S_P_WAIT: begin
        if (tmr_zero) state_d = S_P_VCMD;
      end
      S_P_VCMD: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_PROG_VERIFY;
        if (cmd_fire) state_d = S_P_READ;
      end
      S_P_READ: begin
        cmd_valid = 1'b1;
        cmd_write = 1'b0;
        if (cmd_fire) state_d = S_P_RESP;
      end
      S_P_RESP: begin
        rsp_ready = 1'b1;
        if (rsp_fire) begin
          if (rsp_data == BYTE_CHARGED) begin
            p_clr = 1'b1;
            if (a_last) begin
              a_clr_cur = 1'b1;
              state_d   = S_E_SET1;
            end else begin
              a_inc   = 1'b1;
              state_d = S_P_SETUP;
            end
          end else if (p_limit) begin
            state_d = S_FAIL;
          end else begin
            state_d = S_P_SETUP;
          end
        end
      end
      S_E_SET1: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_ERASE_SETUP;
        if (cmd_fire) state_d = S_E_SET2;
      end
      S_E_SET2: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_ERASE_SETUP;
        if (cmd_fire) begin
          e_inc    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = ERASE_LOAD;
          state_d  = S_E_WAIT;
        end
      end
      S_E_WAIT: begin
        if (tmr_zero) begin
          a_restore = 1'b1;
          state_d   = S_V_CMD;
        end
      end
      S_V_CMD: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_ERASE_VERIFY;
        if (cmd_fire) state_d = S_V_READ;
      end
      S_V_READ: begin
        cmd_valid = 1'b1;
        cmd_write = 1'b0;
        if (cmd_fire) state_d = S_V_RESP;
      end
      S_V_RESP: begin
        rsp_ready = 1'b1;
        if (rsp_fire) begin
          if (rsp_data == BYTE_ERASED) begin
            if (a_last) begin
              state_d = S_FINISH;
            end else begin
              a_inc   = 1'b1;
              state_d = S_V_CMD;
            end
          end else begin
            a_save  = 1'b1;
            state_d = e_limit ? S_FAIL : S_E_SET1;
          end
        end
      end
      S_FINISH: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_READ_ARRAY;
        if (cmd_fire) state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign cmd_addr = cur_addr;
  assign busy     = !(state_q == S_IDLE || state_q == S_DONE || state_q == S_FAIL);
  assign done     = (state_q == S_DONE);
  assign error    = (state_q == S_FAIL);
endmodule

// File: rtl/bulk_erase_seq_chk.sv
module bulk_erase_seq_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [7:0]    cmd_data,
  input logic          rsp_ready,
  input logic [AW-1:0] resume
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_data)); // R10

  AST_RSP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !cmd_valid); // R10

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R9

  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !cmd_valid && !busy); // R11

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R11

  AST_RESUME_UP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> resume >= $past(resume)); // R7
endmodule

bind bulk_erase_seq bulk_erase_seq_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_ready(rsp_ready), .resume(resume_q)
);

// File: tb/bulk_erase_seq_test.sv
module bulk_erase_seq_test;
  localparam int AW    = 4;
  localparam int NB    = 1 << AW;
  localparam int PCYC  = 3;
  localparam int ECYC  = 10;
  localparam int MAXP  = 3;
  localparam int MAXE  = 6;
  localparam int LIMIT = 20000;

  typedef struct packed {
    logic [3:0] mul;
    logic [3:0] off;
    logic [7:0] span;
    logic [3:0] extra;
    logic [3:0] pneed;
    logic       bp;
  } vec_t;

  // erase need per byte = ((a*mul+off) % span) + 1, plus extra on the top byte
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 4'd0, 8'd1, 4'd0, 4'd1, 1'b0},
    '{4'd3, 4'd1, 8'd4, 4'd0, 4'd2, 1'b1},
    '{4'd1, 4'd0, 8'd6, 4'd0, 4'd1, 1'b0},
    '{4'd1, 4'd0, 8'd7, 4'd0, 4'd1, 1'b1},
    '{4'd0, 4'd0, 8'd1, 4'd0, 4'd4, 1'b0},
    '{4'd0, 4'd0, 8'd1, 4'd2, 4'd1, 1'b1},
    '{4'd5, 4'd2, 8'd5, 4'd0, 4'd3, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, error;
  logic          cmd_valid, cmd_write, rsp_ready;
  logic          cmd_ready = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          rsp_valid = 1'b0;
  logic [7:0]    rsp_data = 8'h00;

  always #2 clk = ~clk;

  bulk_erase_seq #(.ADDR_W(AW), .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC),
                   .MAX_PROG(MAXP), .MAX_ERASE(MAXE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int nchk = 0, nerr = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // flash device model state
  logic [7:0] mem [NB];
  int pneed [NB], pcnt [NB], eneed [NB];
  int ec, cyc, t_prog, t_erase, exp_p, exp_ev, mode, last_wr, writes20;
  int v2, v4, v5, v6, v7, v10;
  bit bp, pend, prev_rr, erase_first, hold_q;
  logic [7:0] pend_d, lfsr = 8'h5B;
  logic [AW-1:0] h_addr;
  logic [7:0] h_data;
  logic h_wr;

  localparam int M_RD = 0, M_PSET = 1, M_PV = 2, M_ESET = 3, M_EV = 4;

  task automatic model_step();
    cyc++;
    if (hold_q && (!cmd_valid || cmd_addr != h_addr || cmd_data != h_data || cmd_write != h_wr)) v10++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready = bp ? lfsr[0] : 1'b1;
    if (rsp_valid && prev_rr) rsp_valid = 1'b0;
    if (pend) begin rsp_valid = 1'b1; rsp_data = pend_d; pend = 1'b0; end
    prev_rr = rsp_ready;
    hold_q = cmd_valid && !cmd_ready;
    h_addr = cmd_addr; h_data = cmd_data; h_wr = cmd_write;
    if (cmd_valid && cmd_ready) begin
      if (cmd_write) begin
        last_wr = cmd_data;
        if (mode == M_PSET) begin
          if (cmd_addr != exp_p[AW-1:0] || cmd_data != 8'h00) v2++;
          pcnt[cmd_addr]++;
          if (pcnt[cmd_addr] >= pneed[cmd_addr]) mem[cmd_addr] = 8'h00;
          t_prog = cyc;
          mode = M_RD;
        end else if (cmd_data == 8'h40) begin
          mode = M_PSET;
        end else if (cmd_data == 8'hC0) begin
          if (cyc - t_prog < PCYC || cmd_addr != exp_p[AW-1:0]) v2++;
          mode = M_PV;
        end else if (cmd_data == 8'h20) begin
          writes20++;
          if (mode == M_ESET) begin
            if (ec == 0) for (int a = 0; a < NB; a++) if (mem[a] != 8'h00) v4++;
            ec++;
            for (int a = 0; a < NB; a++) if (ec >= eneed[a]) mem[a] = 8'hFF;
            t_erase = cyc;
            erase_first = 1'b1;
            exp_ev = -1;
            for (int a = NB - 1; a >= 0; a--) if (eneed[a] > ec - 1) exp_ev = a;
            mode = M_RD;
          end else mode = M_ESET;
        end else if (cmd_data == 8'hA0) begin
          if (erase_first) begin
            if (cyc - t_erase < ECYC) v5++;
            if (cmd_addr != exp_ev[AW-1:0]) v7++;
            erase_first = 1'b0;
          end else if (cmd_addr != exp_ev[AW-1:0]) v6++;
          mode = M_EV;
        end else begin
          mode = M_RD;
        end
      end else begin
        pend = 1'b1;
        pend_d = mem[cmd_addr];
        if (mode == M_PV && mem[cmd_addr] == 8'h00 && cmd_addr == exp_p[AW-1:0]) exp_p++;
        if (mode == M_EV) begin
          if (cmd_addr != exp_ev[AW-1:0]) v6++;
          if (mem[cmd_addr] == 8'hFF) exp_ev++;
        end
      end
    end
  endtask

  initial forever begin
    @(negedge clk);
    model_step();
  end

  task automatic load_vec(input vec_t v);
    for (int a = 0; a < NB; a++) begin
      mem[a] = 8'h5A;
      pneed[a] = int'(v.pneed);
      pcnt[a] = 0;
      eneed[a] = ((a * int'(v.mul) + int'(v.off)) % int'(v.span)) + 1;
      if (a == NB - 1) eneed[a] += int'(v.extra);
    end
    bp = v.bp;
    ec = 0; exp_p = 0; exp_ev = 0; mode = M_RD; last_wr = -1; writes20 = 0;
    v2 = 0; v4 = 0; v5 = 0; v6 = 0; v7 = 0; v10 = 0; erase_first = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || error) && n < LIMIT) begin @(negedge clk); n++; end
    check(n < LIMIT, "R8", "watchdog expired", n, LIMIT);
  endtask

  task automatic run_vec(input int idx);
    vec_t v = VECS[idx];
    int worst = 0, exp_p_fail, exp_e_fail, exp_pulses;
    load_vec(v);
    for (int a = 0; a < NB; a++) if (eneed[a] > worst) worst = eneed[a];
    exp_p_fail = (int'(v.pneed) > MAXP);
    exp_e_fail = !exp_p_fail && (worst > MAXE);
    exp_pulses = exp_p_fail ? 0 : (exp_e_fail ? MAXE : worst);
    pulse_start();
    wait_end();
    @(negedge clk);
    if (exp_p_fail) begin
      check(error && !done, "R3", "program limit ends in error", int'(error), 1);
      check(writes20 == 0, "R3", "no erase write after program failure", writes20, 0);
    end else if (exp_e_fail) begin
      check(error && !done, "R9", "erase limit ends in error", int'(error), 1);
    end else begin
      check(done && !error, "R9", "run ends in done", int'(done), 1);
      check(last_wr == 8'h00, "R8", "final write is read-array", last_wr, 0);
    end
    check(ec == exp_pulses, "R5", "erase pulse count", ec, exp_pulses);
    check(v2 == 0, "R2", "precondition sequence violations", v2, 0);
    check(v4 == 0, "R4", "bytes not charged before first erase", v4, 0);
    check(v5 == 0, "R5", "erase wait too short", v5, 0);
    check(v6 == 0, "R6", "verify walk violations", v6, 0);
    check(v7 == 0, "R7", "resume address violations", v7, 0);
    check(v10 == 0, "R10", "stalled command changed", v10, 0);
    repeat (20) @(negedge clk);
    check((done || error) && !busy && !cmd_valid, "R11", "end state held", int'(busy), 0);
  endtask

  initial begin
    bp = 1'b0; pend = 1'b0; prev_rr = 1'b0; hold_q = 1'b0; cyc = 0;
    load_vec(VECS[0]);
    repeat (4) @(negedge clk);
    check(!busy && !done && !error && !cmd_valid, "R1", "state during reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && !cmd_valid, "R1", "state after reset", int'(cmd_valid), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // reset during a run
    load_vec(VECS[1]);
    pulse_start();
    repeat (40) @(negedge clk);
    check(busy, "R1", "run in progress before reset", int'(busy), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error && !cmd_valid, "R1", "mid-run reset clears", int'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pend = 1'b0; rsp_valid = 1'b0;
    repeat (2) @(negedge clk);

    // restart after done from a fresh run
    run_vec(0);
    pulse_start();
    @(negedge clk);
    check(busy && !done, "R11", "start after done begins a new run", int'(busy), 1);
    wait_end();
    check(done, "R11", "second run completes", int'(done), 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule